// File: doc/BRIEF.md
# Successive-Approximation Conversion Sequencer

This block is the digital half of a 10-bit successive-approximation A/D converter inside a small microcontroller. Software reaches it through two write-only registers. The control register carries the input channel, the count of shared port pins given over to analog use, and a start bit. The configuration register carries the conversion-clock divider choice and two interrupt enables. The block does the following:

- It divides the system clock to make the conversion clock.
- It waits for a complete start pulse: the start bit written to 1 and then written back to 0.
- It walks a trial code from the MSB down to the LSB against a single comparator bit supplied from outside.
- It holds the finished code in a pair of 8-bit data registers.

A status flag is high while a conversion is in progress and drops low when the result is ready. Software may poll this flag, or it may use the one-cycle interrupt request that is raised when both enables are set.

A change of input channel puts the converter into a stale state, in which the status flag is not trustworthy. The first start pulse after the change only re-arms the flag high. It produces no result and no interrupt. The analog-enable mask tells the port logic which pins to take over: their direction control is overridden and their pull-ups are dropped.

Top module: `adc_conv_ctrl`

## Requirements
- R1: Configuration bits [1:0] select the conversion-clock period in system-clock cycles: 0 gives 2, 1 gives 8, 2 gives 32. The value 3 is reserved and yields no conversion-clock ticks, so a conversion started under it makes no progress until a valid divider is selected.
- R2: A conversion starts on the clock edge where a control-register write (bit 6 = start) clears a start bit that is currently 1. Writing start = 1 alone starts nothing.
- R3: The status flag `eoc_flag` is low after reset. It is high from the start edge onward and falls exactly 10 conversion-clock periods (10 x divider system cycles) after the start edge.
- R4: Each result bit takes one conversion-clock period, MSB first. A trial bit is kept when `cmp_in` is 1 while `dac_code` presents that trial. With `cmp_in = (vin >= dac_code)`, the result equals vin.
- R5: Any control-register write whose bits [2:0] differ from the current channel aborts a running conversion and drives `eoc_flag` low. The next start pulse only sets `eoc_flag` high: the data registers are unchanged, no interrupt is raised, and no conversion runs. The start pulse after that converts normally.
- R6: `irq` pulses for exactly one cycle, together with the falling edge of `eoc_flag` at the end of a conversion, only if configuration bit 3 (global enable) and bit 2 (converter enable) are both 1. Otherwise `irq` stays 0 and the flag still falls.
- R7: Control bits [5:3] hold a pin count N. `ana_en` has its lowest N bits set and all others clear, so N = 0 makes no pin analog.
- R8: `res_hi` holds result bits [9:2]. `res_lo` holds result bits [1:0] in its bits [7:6], with zeros below. Both registers change only on the edge where a conversion ends, and both are 0 after reset.
- R9: A start pulse during a conversion abandons it and restarts from the MSB. The flag then falls 10 conversion-clock periods after the new start edge, with the result for the current input.
- R10: While a conversion runs, `dac_code` equals the bits kept so far plus the current trial bit. When no conversion runs, `dac_code` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = control register, 1 = configuration register |
| reg_wdata | input | 8 | Write data |
| cmp_in | input | 1 | Comparator decision: input is at or above `dac_code` |
| dac_code | output | 10 | Trial code presented to the comparator |
| eoc_flag | output | 1 | High while converting, low when the result is ready |
| res_hi | output | 8 | Upper eight result bits |
| res_lo | output | 8 | Lower two result bits, left-justified |
| irq | output | 1 | One-cycle interrupt request, gated by both enables |
| ana_en | output | 8 | Per-pin analog enable mask for the shared port |
| chan_sel | output | 3 | Selected analog channel |

## Verification
The main conversion is driven with every input value from 0 to 1023 at the fastest divider. This sweep separates the keep/drop decision of each bit position, including the all-zero, all-one and alternating codes, and confirms the split across the two data registers. Selected codes are repeated at the two slower dividers and under the reserved setting, which tells a correct tick count apart from an off-by-one or a wrong ratio. A channel change followed by a dummy pulse, and a restart in the middle of a conversion, separate the re-arm path from a real conversion and an abort from a continued one. Every pin count 0 to 7 and all four interrupt-enable combinations are also tried.

// File: rtl/adc_ctrl_pkg.sv
// Package: shared constants, the divider-select type and the divider ratio
// function for the conversion sequencer. Assumes 8-bit data registers.
package adc_ctrl_pkg;

    localparam int RES_W  = 10;          // result width
    localparam int DATA_W = 8;           // register data width
    localparam int LO_W   = RES_W - DATA_W;
    localparam int CHAN_W = 3;
    localparam int PCFG_W = 3;
    localparam int DIV_W  = 6;

    typedef enum logic [1:0] {
        CK_DIV2  = 2'd0,
        CK_DIV8  = 2'd1,
        CK_DIV32 = 2'd2,
        CK_RSVD  = 2'd3
    } clk_sel_e;

    // System cycles per conversion-clock period; 0 marks the reserved code.
    function automatic logic [DIV_W-1:0] div_of(clk_sel_e s);
        case (s)
            CK_DIV2:  return DIV_W'(2);
            CK_DIV8:  return DIV_W'(8);
            CK_DIV32: return DIV_W'(32);
            default:  return '0;
        endcase
    endfunction

endpackage

// File: rtl/adc_clk_div.sv
// Conversion-clock divider: emits a one-cycle tick every div_of(sel) system
// cycles while enabled. Assumes restart is asserted on each conversion start
// so that the first tick lands a full period later. Reserved select: no ticks.
module adc_clk_div
    import adc_ctrl_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     en,
    input  logic     restart,
    input  clk_sel_e sel,
    output logic     tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] ratio;

    assign ratio = div_of(sel);
    assign tick  = en && !restart && (ratio != '0) && (cnt_q >= ratio - 1'b1);

    // Count system cycles within the current conversion-clock period.
    always_ff @(posedge clk) begin
        if (!rst_n || restart || !en) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= '0;
        end else if (ratio != '0) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/adc_sar_engine.sv
// Successive-approximation engine: one decision per tick, MSB first.
// Assumes cmp_in reflects the dac_code presented in the same cycle.
// start restarts from the MSB; abort drops the conversion without result.
module adc_sar_engine
    import adc_ctrl_pkg::*;
#(
    parameter int W = RES_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic         abort,
    input  logic         tick,
    input  logic         cmp_in,
    output logic         busy,
    output logic         done,
    output logic [W-1:0] result,
    output logic [W-1:0] dac_code
);

    localparam int IDX_W = $clog2(W);

    logic [W-1:0]     acc_q;
    logic [IDX_W-1:0] idx_q;
    logic             busy_q;
    logic [W-1:0]     trial_bit;

    assign trial_bit = {{(W-1){1'b0}}, 1'b1} << idx_q;
    assign busy      = busy_q;
    assign dac_code  = busy_q ? (acc_q | trial_bit) : '0;
    assign done      = busy_q && tick && (idx_q == '0) && !start && !abort;
    assign result    = cmp_in ? (acc_q | trial_bit) : acc_q;

    // Step the approximation register one bit per conversion-clock tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            acc_q  <= '0;
            idx_q  <= '0;
        end else if (abort) begin
            busy_q <= 1'b0;
            acc_q  <= '0;
            idx_q  <= '0;
        end else if (start) begin
            busy_q <= 1'b1;
            acc_q  <= '0;
            idx_q  <= IDX_W'(W - 1);
        end else if (busy_q && tick) begin
            if (cmp_in) begin
                acc_q <= acc_q | trial_bit;
            end
            if (idx_q == '0) begin
                busy_q <= 1'b0;
            end else begin
                idx_q <= idx_q - 1'b1;
            end
        end
    end

endmodule

// File: rtl/adc_pin_mask.sv
// Analog pin mask: the lowest pin_cnt pins become analog inputs.
// Assumes PIN_N is at least 2**PCFG_W - 1 so every count fits.
module adc_pin_mask
    import adc_ctrl_pkg::*;
#(
    parameter int PIN_N = 8
) (
    input  logic [PCFG_W-1:0] pin_cnt,
    output logic [PIN_N-1:0]  ana_en
);

    for (genvar i = 0; i < PIN_N; i++) begin : g_pin
        assign ana_en[i] = (int'(pin_cnt) > i);
    end

endmodule

// File: rtl/adc_conv_ctrl.sv
// Conversion sequencer top: register decode, start-pulse detection, stale
// channel handling, status flag, result registers and interrupt gating.
// Assumes single-cycle register writes and an external comparator.
module adc_conv_ctrl
    import adc_ctrl_pkg::*;
#(
    parameter int PIN_N = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic              reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              cmp_in,
    output logic [RES_W-1:0]  dac_code,
    output logic              eoc_flag,
    output logic [DATA_W-1:0] res_hi,
    output logic [DATA_W-1:0] res_lo,
    output logic              irq,
    output logic [PIN_N-1:0]  ana_en,
    output logic [CHAN_W-1:0] chan_sel
);

    logic [CHAN_W-1:0] chan_q;
    logic [PCFG_W-1:0] pin_cfg_q;
    logic              start_q;
    clk_sel_e          clk_sel_q;
    logic              ad_ie_q;
    logic              glb_ie_q;
    logic              stale_q;
    logic              eoc_q;
    logic [RES_W-1:0]  res_q;
    logic              irq_q;

    logic              wr_ctrl;
    logic              wr_cfg;
    logic              chan_change;
    logic              pulse;
    logic              conv_start;
    logic              tick;
    logic              busy;
    logic              done;
    logic [RES_W-1:0]  sar_result;
    logic              unused_wdata;

    assign wr_ctrl      = reg_wr && !reg_addr;
    assign wr_cfg       = reg_wr && reg_addr;
    assign chan_change  = wr_ctrl && (reg_wdata[CHAN_W-1:0] != chan_q);
    assign pulse        = wr_ctrl && start_q && !reg_wdata[6] && !chan_change;
    assign conv_start   = pulse && !stale_q;
    assign unused_wdata = reg_wdata[7];

    // Control and configuration register writes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            chan_q    <= '0;
            pin_cfg_q <= '0;
            start_q   <= 1'b0;
            clk_sel_q <= CK_DIV2;
            ad_ie_q   <= 1'b0;
            glb_ie_q  <= 1'b0;
        end else if (wr_ctrl) begin
            chan_q    <= reg_wdata[CHAN_W-1:0];
            pin_cfg_q <= reg_wdata[5:3];
            start_q   <= reg_wdata[6];
        end else if (wr_cfg) begin
            clk_sel_q <= clk_sel_e'(reg_wdata[1:0]);
            ad_ie_q   <= reg_wdata[2];
            glb_ie_q  <= reg_wdata[3];
        end
    end

    // Stale-channel tracking and the end-of-conversion status flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stale_q <= 1'b0;
            eoc_q   <= 1'b0;
        end else if (chan_change) begin
            stale_q <= 1'b1;
            eoc_q   <= 1'b0;
        end else if (pulse) begin
            stale_q <= 1'b0;
            eoc_q   <= 1'b1;
        end else if (done) begin
            eoc_q   <= 1'b0;
        end
    end

    // Result latch and interrupt request on conversion completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= done && ad_ie_q && glb_ie_q;
            if (done) begin
                res_q <= sar_result;
            end
        end
    end

    adc_clk_div u_div (
        .clk     (clk),
        .rst_n   (rst_n),
        .en      (busy),
        .restart (conv_start),
        .sel     (clk_sel_q),
        .tick    (tick)
    );

    adc_sar_engine #(.W(RES_W)) u_sar (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (conv_start),
        .abort    (chan_change),
        .tick     (tick),
        .cmp_in   (cmp_in),
        .busy     (busy),
        .done     (done),
        .result   (sar_result),
        .dac_code (dac_code)
    );

    adc_pin_mask #(.PIN_N(PIN_N)) u_mask (
        .pin_cnt (pin_cfg_q),
        .ana_en  (ana_en)
    );

    assign eoc_flag = eoc_q;
    assign res_hi   = res_q[RES_W-1 -: DATA_W];
    assign res_lo   = {res_q[LO_W-1:0], {(DATA_W-LO_W){1'b0}}};
    assign irq      = irq_q;
    assign chan_sel = chan_q;

endmodule

// File: rtl/adc_conv_ctrl_chk.sv
// Property checker for the conversion sequencer, bound to every instance.
module adc_conv_ctrl_chk
    import adc_ctrl_pkg::*;
#(
    parameter int PIN_N = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              eoc_flag,
    input logic [DATA_W-1:0] res_hi,
    input logic [DATA_W-1:0] res_lo,
    input logic              irq,
    input logic [PIN_N-1:0]  ana_en,
    input logic [PCFG_W-1:0] pin_cfg,
    input logic              ad_ie,
    input logic              glb_ie,
    input logic              busy,
    input logic [RES_W-1:0]  dac_code,
    input clk_sel_e          clk_sel,
    input logic              tick
);

    assert_reserved_no_tick_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_sel == CK_RSVD) |-> !tick);

    assert_flag_high_busy_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> eoc_flag);

    assert_irq_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $past(ad_ie && glb_ie));

    assert_irq_with_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> $fell(eoc_flag));

    assert_mask_count_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(ana_en) == int'(pin_cfg));

    assert_mask_contig_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((ana_en + 1'b1) & ana_en) == '0);

    assert_result_on_fall_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !($stable(res_hi) && $stable(res_lo)) |-> $fell(eoc_flag));

    assert_dac_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (dac_code == '0));

    assert_dac_trial_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (dac_code != '0));

endmodule

bind adc_conv_ctrl adc_conv_ctrl_chk #(.PIN_N(PIN_N)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .eoc_flag (eoc_flag),
    .res_hi   (res_hi),
    .res_lo   (res_lo),
    .irq      (irq),
    .ana_en   (ana_en),
    .pin_cfg  (pin_cfg_q),
    .ad_ie    (ad_ie_q),
    .glb_ie   (glb_ie_q),
    .busy     (busy),
    .dac_code (dac_code),
    .clk_sel  (clk_sel_q),
    .tick     (tick)
);

// File: tb/adc_conv_ctrl_bench.sv
// Self-checking bench: exhaustive code sweep at the fastest divider plus
// directed timing, stale-channel, abort, mask and interrupt cases.
module adc_conv_ctrl_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic       reg_addr = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [9:0] vin = '0;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       eoc_flag;
    logic [7:0] res_hi;
    logic [7:0] res_lo;
    logic       irq;
    logic [7:0] ana_en;
    logic [2:0] chan_sel;

    int checks = 0;
    int failures = 0;
    bit finished = 0;
    logic [2:0] cur_chan = 3'd0;

    always #10 clk = ~clk;   // 50 MHz

    assign cmp_in = (vin >= dac_code);

    adc_conv_ctrl u_adc_conv_ctrl (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .cmp_in(cmp_in), .dac_code(dac_code),
        .eoc_flag(eoc_flag), .res_hi(res_hi), .res_lo(res_lo), .irq(irq),
        .ana_en(ana_en), .chan_sel(chan_sel)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    // Control write: start at bit 6, pin count at [5:3], channel at [2:0].
    task automatic wr_ctrl(input logic st, input logic [2:0] pins, input logic [2:0] ch);
        wr(1'b0, {1'b0, st, pins, ch});
        cur_chan = ch;
    endtask

    // Configuration: divider [1:0], converter enable bit 2, global enable bit 3.
    task automatic wr_cfg(input logic [1:0] sel, input logic adie, input logic gie);
        wr(1'b1, {4'b0, gie, adie, sel});
    endtask

    task automatic pulse(input logic [2:0] pins);
        wr_ctrl(1'b1, pins, cur_chan);
        wr_ctrl(1'b0, pins, cur_chan);
    endtask

    // Cycles from the start edge until eoc_flag reads low; irq seen at the fall.
    task automatic wait_eoc(input int limit, output int n, output logic irq_at);
        n = 0;
        while (eoc_flag && n < limit) begin
            @(negedge clk);
            n++;
        end
        irq_at = irq;
    endtask

    task automatic check_result(input logic [9:0] v, input string req);
        chk(res_hi == v[9:2], req, res_hi, v[9:2]);
        chk(res_lo == {v[1:0], 6'b0}, req, res_lo, {v[1:0], 6'b0});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin : main
        int n;
        logic irq_at;
        logic [7:0] h0;
        logic [7:0] l0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // Reset state (R3, R8, R10, R7)
        chk(eoc_flag == 1'b0, "R3 reset flag", eoc_flag, 0);
        chk(res_hi == 8'd0 && res_lo == 8'd0, "R8 reset data", res_hi, 0);
        chk(dac_code == 10'd0, "R10 idle code", dac_code, 0);
        chk(irq == 1'b0, "R6 reset irq", irq, 0);
        chk(ana_en == 8'd0, "R7 reset mask", ana_en, 0);

        // R2: writing start=1 alone does not begin a conversion
        wr_cfg(2'd0, 1'b1, 1'b1);
        wr_ctrl(1'b1, 3'd0, 3'd0);
        repeat (3) @(negedge clk);
        chk(eoc_flag == 1'b0, "R2 set only", eoc_flag, 0);
        chk(dac_code == 10'd0, "R2 no trial", dac_code, 0);
        wr_ctrl(1'b0, 3'd0, 3'd0);
        wait_eoc(100, n, irq_at);

        // R4/R8/R3/R6: exhaustive sweep at divider 2, both enables on
        for (int v = 0; v < 1024; v++) begin
            vin = 10'(v);
            pulse(3'd0);
            chk(eoc_flag == 1'b1, "R3 flag high", eoc_flag, 1);
            wait_eoc(100, n, irq_at);
            chk(n == 20, "R3 timing div2", n, 20);
            check_result(10'(v), "R4 sweep");
            chk(irq_at == 1'b1, "R6 irq", irq_at, 1);
            @(negedge clk);
            chk(irq == 1'b0, "R6 one cycle", irq, 0);
        end

        // R1/R3: slower dividers
        for (int s = 1; s < 3; s++) begin
            int d;
            d = (s == 1) ? 8 : 32;
            foreach (h0[k]) begin
                vin = 10'((k * 131 + s * 77) % 1024);
                wr_cfg(2'(s), 1'b0, 1'b0);
                pulse(3'd0);
                wait_eoc(1000, n, irq_at);
                chk(n == 10 * d, "R1 divider period", n, 10 * d);
                check_result(vin, "R4 slow divider");
                chk(irq_at == 1'b0, "R6 enables off", irq_at, 0);
            end
        end

        // R6: each enable alone blocks the request
        for (int e = 1; e < 3; e++) begin
            vin = 10'd300;
            wr_cfg(2'd0, e[0], e[1]);
            pulse(3'd0);
            wait_eoc(100, n, irq_at);
            chk(irq_at == 1'b0 && n == 20, "R6 single enable", irq_at, 0);
        end

        // R1: reserved setting stalls, then a valid divider finishes it
        vin = 10'd555;
        wr_cfg(2'd3, 1'b0, 1'b0);
        pulse(3'd0);
        repeat (200) @(negedge clk);
        chk(eoc_flag == 1'b1, "R1 reserved stalls", eoc_flag, 1);
        chk(dac_code == 10'h200, "R1 still at MSB", dac_code, 10'h200);
        wr_cfg(2'd0, 1'b0, 1'b0);
        wait_eoc(100, n, irq_at);
        check_result(10'd555, "R1 resumed");

        // R5: channel change, dummy pulse, then a real conversion
        h0 = res_hi; l0 = res_lo;
        vin = 10'd777;
        wr_cfg(2'd0, 1'b1, 1'b1);
        wr_ctrl(1'b0, 3'd0, 3'd5);
        chk(eoc_flag == 1'b0, "R5 stale flag low", eoc_flag, 0);
        chk(chan_sel == 3'd5, "R5 channel", chan_sel, 5);
        pulse(3'd0);
        irq_at = 1'b0;
        for (int c = 0; c < 40; c++) begin
            @(negedge clk);
            if (irq) irq_at = 1'b1;
        end
        chk(eoc_flag == 1'b1, "R5 dummy sets flag", eoc_flag, 1);
        chk(res_hi == h0 && res_lo == l0, "R5 dummy no result", res_hi, h0);
        chk(irq_at == 1'b0, "R5 dummy no irq", irq_at, 0);
        chk(dac_code == 10'd0, "R5 dummy no conversion", dac_code, 0);
        pulse(3'd0);
        wait_eoc(100, n, irq_at);
        chk(n == 20, "R5 real after dummy", n, 20);
        check_result(10'd777, "R5 result");

        // R5: channel change aborts a running conversion
        vin = 10'd100;
        wr_cfg(2'd1, 1'b0, 1'b0);
        pulse(3'd0);
        repeat (10) @(negedge clk);
        h0 = res_hi;
        wr_ctrl(1'b0, 3'd0, 3'd2);
        chk(eoc_flag == 1'b0 && dac_code == 10'd0, "R5 abort", eoc_flag, 0);
        repeat (100) @(negedge clk);
        chk(res_hi == h0, "R5 abort no result", res_hi, h0);
        pulse(3'd0);

        // R9: restart in the middle of a conversion
        vin = 10'd1000;
        pulse(3'd0);
        repeat (30) @(negedge clk);
        vin = 10'd42;
        pulse(3'd0);
        wait_eoc(1000, n, irq_at);
        chk(n == 80, "R9 restart timing", n, 80);
        check_result(10'd42, "R9 restart result");

        // R7: every pin count
        for (int p = 0; p < 8; p++) begin
            wr_ctrl(1'b0, 3'(p), cur_chan);
            chk(ana_en == 8'((1 << p) - 1), "R7 mask", ana_en, (1 << p) - 1);
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule